// File: doc/BRIEF.md
# Infrared SIR Pulse Encoder

This block turns a conventional NRZ serial transmit line into the short return-to-zero light pulses used by serial infrared links. It runs from a system clock and a single-cycle enable that fires sixteen times per bit period. All of its timing is counted in those enable ticks, so one bit period is sixteen ticks.

A falling edge on the serial line opens a bit slot, and a phase counter marks the position inside that slot. Partway into the slot the line is sampled. If the sample is a zero, a pulse is emitted that lasts a fixed number of ticks, centred in the slot. A one produces no pulse. When zeros follow one another with no edge between them, the counter wraps at the end of each slot, so the pulses keep the same spacing. When a slot samples a one, the encoder goes back to idle at the end of that slot and realigns on the next falling edge.

Top module: `sir_pulse_encoder`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives `ir_pulse` low and leaves the slot timer idle. After reset the encoder produces no pulse until a falling edge is seen.
- R2: Slot timing and `ir_pulse` change only on clock edges where `baud16_en` is high. Between such ticks the output holds its value.
- R3: A tick that sees `ser_in` low after the previous tick saw it high is a falling edge. That tick becomes phase 0 of a new slot.
- R4: `ir_pulse` rises on the tick at phase 7 when `ser_in` is 0 on that tick, which is seven ticks after phase 0.
- R5: Once raised, `ir_pulse` stays high for exactly 3 ticks (phases 7, 8 and 9) and is low on the tick at phase 10.
- R6: A slot whose phase-7 sample of `ser_in` is 1 produces no pulse, and `ir_pulse` stays low for all 16 ticks of that slot.
- R7: Back-to-back zero bits with no edge between them produce pulses exactly 16 ticks apart, because the phase wraps from 15 to 0.
- R8: A new falling edge in the middle of a slot restarts the phase at 0. Any pulse still pending from the old alignment is dropped, and the next pulse comes 7 ticks after the new edge.
- R9: At the end of a slot that sampled a one, the encoder returns to idle. A later zero is then timed from its own falling edge, whatever the tick offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| baud16_en | input | 1 | One-cycle enable at sixteen times the bit rate |
| ser_in | input | 1 | NRZ serial transmit line; idle level is high |
| ir_pulse | output | 1 | Registered infrared pulse output; high means emit |

## Verification
A pulse is due on the output right after the seventh tick following the tick that saw the falling edge. It stays up through the tick edges at phases 7, 8 and 9 and drops at the phase-10 tick. The bench therefore samples `ir_pulse` on the falling clock edge after each tick and compares whole 16-tick slot patterns, with the set bits at positions 7 to 9, against a pattern it derives from the bit value alone. Directed runs use the same per-tick sampling to place the realigned pulse 7 ticks after a mid-slot edge. They also watch the output on clock edges without a tick to confirm that nothing moves there.

// File: rtl/sir_enc_pkg.sv
package sir_enc_pkg;

    // Slot timer mode: waiting for an edge, or counting phases in a slot
    typedef enum logic {
        SLOT_IDLE = 1'b0,
        SLOT_RUN  = 1'b1
    } slot_mode_e;

endpackage

// File: rtl/sir_fall_detect.sv
module sir_fall_detect (
    input  logic clk,
    input  logic rst,
    input  logic baud16_en,
    input  logic ser_in,
    output logic fall
);

    typedef struct packed {
        logic line;
    } fd_state_t;

    fd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (baud16_en) begin
            st_d.line = ser_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.line <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // Edge is seen on a tick: the line was high last tick and is low now
    assign fall = baud16_en && st_q.line && !ser_in;

endmodule

// File: rtl/sir_slot_timer.sv
module sir_slot_timer
    import sir_enc_pkg::*;
#(
    parameter int SLOT_TICKS = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          baud16_en,
    input  logic                          fall,
    input  logic                          bit_zero,
    output logic [$clog2(SLOT_TICKS)-1:0] phase_q,
    output logic [$clog2(SLOT_TICKS)-1:0] phase_nx,
    output slot_mode_e                    mode_q,
    output slot_mode_e                    mode_nx
);

    localparam int PH_W = $clog2(SLOT_TICKS);
    localparam logic [PH_W-1:0] LAST = PH_W'(SLOT_TICKS - 1);

    typedef struct packed {
        logic [PH_W-1:0] phase;
        slot_mode_e      mode;
    } tm_state_t;

    tm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (baud16_en) begin
            if (fall) begin
                st_d.phase = '0;
                st_d.mode  = SLOT_RUN;
            end else if (st_q.mode == SLOT_RUN) begin
                if (st_q.phase == LAST) begin
                    st_d.phase = '0;
                    if (!bit_zero) begin
                        st_d.mode = SLOT_IDLE;
                    end
                end else begin
                    st_d.phase = st_q.phase + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase <= '0;
            st_q.mode  <= SLOT_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_q  = st_q.phase;
    assign phase_nx = st_d.phase;
    assign mode_q   = st_q.mode;
    assign mode_nx  = st_d.mode;

endmodule

// File: rtl/sir_pulse_shaper.sv
module sir_pulse_shaper
    import sir_enc_pkg::*;
#(
    parameter int SLOT_TICKS  = 16,
    parameter int PULSE_DELAY = 7,
    parameter int PULSE_WIDTH = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          baud16_en,
    input  logic                          fall,
    input  logic                          ser_in,
    input  logic [$clog2(SLOT_TICKS)-1:0] phase_nx,
    input  slot_mode_e                    mode_nx,
    output logic                          bit_zero,
    output logic                          ir_pulse
);

    localparam int PH_W = $clog2(SLOT_TICKS);
    localparam logic [PH_W-1:0] P_START = PH_W'(PULSE_DELAY);
    localparam logic [PH_W:0]   P_END   = (PH_W + 1)'(PULSE_DELAY + PULSE_WIDTH);

    typedef struct packed {
        logic zero;
        logic pulse;
    } ps_state_t;

    ps_state_t st_d, st_q;
    logic      in_window;
    logic      at_sample;

    always_comb begin
        at_sample = (mode_nx == SLOT_RUN) && (phase_nx == P_START);
        in_window = (mode_nx == SLOT_RUN) && (phase_nx >= P_START) &&
                    ({1'b0, phase_nx} < P_END);
        st_d = st_q;
        if (baud16_en) begin
            if (at_sample) begin
                st_d.zero = !ser_in;
            end else if (fall) begin
                st_d.zero = 1'b0;
            end
            st_d.pulse = in_window && (at_sample ? !ser_in : st_q.zero);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.zero  <= 1'b0;
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_zero = st_q.zero;
    assign ir_pulse = st_q.pulse;

endmodule

// File: rtl/sir_pulse_encoder.sv
module sir_pulse_encoder
    import sir_enc_pkg::*;
#(
    parameter int SLOT_TICKS  = 16,
    parameter int PULSE_DELAY = 7,
    parameter int PULSE_WIDTH = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic baud16_en,
    input  logic ser_in,
    output logic ir_pulse
);

    localparam int PH_W = $clog2(SLOT_TICKS);

    logic            fall;
    logic            bit_zero;
    logic [PH_W-1:0] slot_phase_q;
    logic [PH_W-1:0] slot_phase_nx;
    slot_mode_e      slot_mode_q;
    slot_mode_e      slot_mode_nx;

    sir_fall_detect i_fall (
        .clk       (clk),
        .rst       (rst),
        .baud16_en (baud16_en),
        .ser_in    (ser_in),
        .fall      (fall)
    );

    sir_slot_timer #(
        .SLOT_TICKS (SLOT_TICKS)
    ) i_timer (
        .clk       (clk),
        .rst       (rst),
        .baud16_en (baud16_en),
        .fall      (fall),
        .bit_zero  (bit_zero),
        .phase_q   (slot_phase_q),
        .phase_nx  (slot_phase_nx),
        .mode_q    (slot_mode_q),
        .mode_nx   (slot_mode_nx)
    );

    sir_pulse_shaper #(
        .SLOT_TICKS  (SLOT_TICKS),
        .PULSE_DELAY (PULSE_DELAY),
        .PULSE_WIDTH (PULSE_WIDTH)
    ) i_shaper (
        .clk       (clk),
        .rst       (rst),
        .baud16_en (baud16_en),
        .fall      (fall),
        .ser_in    (ser_in),
        .phase_nx  (slot_phase_nx),
        .mode_nx   (slot_mode_nx),
        .bit_zero  (bit_zero),
        .ir_pulse  (ir_pulse)
    );

endmodule

// File: rtl/sir_pulse_encoder_chk.sv
module sir_pulse_encoder_chk
    import sir_enc_pkg::*;
#(
    parameter int SLOT_TICKS  = 16,
    parameter int PULSE_DELAY = 7,
    parameter int PULSE_WIDTH = 3
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          baud16_en,
    input logic                          ser_in,
    input logic                          ir_pulse,
    input logic [$clog2(SLOT_TICKS)-1:0] phase,
    input slot_mode_e                    mode
);

    localparam int PH_W = $clog2(SLOT_TICKS);
    localparam logic [PH_W-1:0] C_LAST  = PH_W'(SLOT_TICKS - 1);
    localparam logic [PH_W-1:0] C_DLY   = PH_W'(PULSE_DELAY);
    localparam logic [PH_W-1:0] C_PRE   = PH_W'(PULSE_DELAY - 1);
    localparam logic [PH_W:0]   C_END   = (PH_W + 1)'(PULSE_DELAY + PULSE_WIDTH);

    // Independent view of the line level seen on the previous tick
    logic line_seen;
    logic fall_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_seen <= 1'b1;
        end else if (baud16_en) begin
            line_seen <= ser_in;
        end
    end

    assign fall_seen = baud16_en && line_seen && !ser_in;

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!ir_pulse && mode == SLOT_IDLE));

    p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (rst)
        !baud16_en |=> ($stable(ir_pulse) && $stable(phase)));

    p_fall_restart_r3: assert property (@(posedge clk) disable iff (rst)
        fall_seen |=> (phase == '0 && mode == SLOT_RUN));

    p_rise_at_delay_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(ir_pulse) |-> (phase == C_DLY));

    p_pulse_window_r5: assert property (@(posedge clk) disable iff (rst)
        ir_pulse |-> (mode == SLOT_RUN && phase >= C_DLY && {1'b0, phase} < C_END));

    p_mark_no_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        (baud16_en && mode == SLOT_RUN && phase == C_PRE && ser_in && !fall_seen)
        |=> !ir_pulse);

    p_phase_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (baud16_en && mode == SLOT_RUN && phase == C_LAST && !fall_seen)
        |=> (phase == '0));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (mode == SLOT_IDLE) |-> (!ir_pulse && phase == '0));

endmodule

bind sir_pulse_encoder sir_pulse_encoder_chk #(
    .SLOT_TICKS  (SLOT_TICKS),
    .PULSE_DELAY (PULSE_DELAY),
    .PULSE_WIDTH (PULSE_WIDTH)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .baud16_en (baud16_en),
    .ser_in    (ser_in),
    .ir_pulse  (ir_pulse),
    .phase     (slot_phase_q),
    .mode      (slot_mode_q)
);

// File: tb/test_sir_pulse_encoder.sv
module test_sir_pulse_encoder;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic baud16_en = 1'b0;
    logic ser_in = 1'b1;
    logic ir_pulse;

    int n_tests = 0;
    int n_fail  = 0;
    int rises   = 0;
    logic prev_out = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    sir_pulse_encoder i_sir_pulse_encoder (
        .clk       (clk),
        .rst       (rst),
        .baud16_en (baud16_en),
        .ser_in    (ser_in),
        .ir_pulse  (ir_pulse)
    );

    // Frames sent LSB first, each followed by two mark slots; expected pulse count
    localparam logic [7:0] FRAME  [6] = '{8'h00, 8'hFF, 8'h55, 8'h0F, 8'hA5, 8'h81};
    localparam int         NPULSE [6] = '{8, 0, 4, 4, 4, 6};
    localparam logic [15:0] ZERO_SLOT = 16'h0380;   // ticks 7, 8, 9 high

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // One enable tick; output sampled on the falling edge after it
    task automatic tick_once(output logic v);
        @(negedge clk);
        baud16_en = 1'b1;
        @(negedge clk);
        baud16_en = 1'b0;
        v = ir_pulse;
        if (v && !prev_out) rises++;
        prev_out = v;
    endtask

    task automatic run_slot(input logic b);
        logic [15:0] got;
        logic [15:0] exp;
        logic v;
        ser_in = b;
        for (int k = 0; k < 16; k++) begin
            tick_once(v);
            got[k] = v;
        end
        exp = b ? 16'h0000 : ZERO_SLOT;
        if (b) check(got == exp, "R6", "mark slot", int'(got), int'(exp));
        else   check(got == exp, "R4/R5/R7", "zero slot", int'(got), int'(exp));
    endtask

    initial begin
        logic v;
        logic [21:0] got22;
        logic held;
        repeat (3) @(negedge clk);
        check(ir_pulse == 1'b0, "R1", "output in reset", int'(ir_pulse), 0);
        rst = 1'b0;

        // Idle line after reset: no pulse (R1)
        got22 = '0;
        for (int k = 0; k < 20; k++) begin
            tick_once(v);
            got22[k] = v;
        end
        check(got22 == '0, "R1", "idle after reset", int'(got22), 0);

        // Vector table: R3 edges, R4/R5 pulses, R6 marks, R7 runs of zeros
        for (int f = 0; f < 6; f++) begin
            rises = 0;
            for (int b = 0; b < 8; b++) run_slot(FRAME[f][b]);
            run_slot(1'b1);
            run_slot(1'b1);
            check(rises == NPULSE[f], "R3/R7", "pulse count per frame", rises, NPULSE[f]);
        end

        // R9: idle after a mark slot, then a zero at an odd tick offset
        ser_in = 1'b1;
        for (int k = 0; k < 5; k++) tick_once(v);
        run_slot(1'b0);
        run_slot(1'b1);

        // R8: mid-slot falling edge restarts the phase
        ser_in = 1'b0;
        got22 = '0;
        for (int k = 0; k < 22; k++) begin
            ser_in = (k == 4 || k == 5) ? 1'b1 : 1'b0;
            tick_once(v);
            got22[k] = v;
        end
        check(got22 == 22'h00E000, "R8", "realigned pulse ticks", int'(got22), 'hE000);
        ser_in = 1'b1;
        repeat (3) run_slot(1'b1);

        // R2: no change while the enable is low during a pulse
        ser_in = 1'b0;
        for (int k = 0; k < 8; k++) tick_once(v);
        check(v == 1'b1, "R4", "high after 8th tick", int'(v), 1);
        held = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (ir_pulse !== 1'b1) held = 1'b0;
        end
        check(held == 1'b1, "R2", "held without ticks", int'(held), 1);
        tick_once(v);
        check(v == 1'b1, "R5", "phase 8 high", int'(v), 1);
        tick_once(v);
        check(v == 1'b1, "R5", "phase 9 high", int'(v), 1);
        tick_once(v);
        check(v == 1'b0, "R5", "phase 10 low", int'(v), 0);

        // R1: reset in the middle of a pulse
        for (int k = 11; k < 16; k++) tick_once(v);
        for (int k = 0; k < 8; k++) tick_once(v);
        check(v == 1'b1, "R7", "second zero slot pulse", int'(v), 1);
        @(negedge clk);
        rst = 1'b1;
        ser_in = 1'b1;
        @(negedge clk);
        check(ir_pulse == 1'b0, "R1", "reset clears pulse", int'(ir_pulse), 0);
        rst = 1'b0;
        got22 = '0;
        for (int k = 0; k < 20; k++) begin
            tick_once(v);
            got22[k] = v;
        end
        check(got22 == '0, "R1", "idle after mid-pulse reset", int'(got22), 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule